// File: doc/BRIEF.md
# PLL Lock-Loss Recovery Controller

This controller supervises the lock indication of an on-chip PLL that, once it has lost lock, may stay unlocked unless it is reset. It runs from a free-running reference clock that does not come from the PLL. The lock input passes through a two-flop synchronizer before any decision uses it. When lock falls during normal operation, the controller runs a fixed sequence. It first clears a set of clock-enable outputs that drive glitch-free gating cells. It then pulses the PLL's active-low power-down line for a set time. Last, it waits until lock has stayed high for a qualifying window and only then enables the clocks again.

Downstream logic sees a stopped clock for the whole recovery. If lock fails to come back within a timeout after the power-down line is released, the power-down pulse is repeated and a sticky flag records the retry. A saturating counter records how many times lock was lost. A status output marks the interval in which recovery is in progress. After reset the controller gates the clocks and starts with a power-down pulse, so the PLL always starts from a known state.

Top module: `pll_relock_ctrl`

## Requirements
- R1: The controller samples `lock_in` through a two-flop synchronizer. A low on `lock_in` while the clocks are enabled clears every clock enable within 4 reference cycles of the fall.
- R2: `pll_pd_n_o` never goes low while any clock enable is high, and it falls at least one cycle after the enables have fallen.
- R3: Each power-down pulse holds `pll_pd_n_o` low for exactly PD_CYCLES reference cycles and then drives it high.
- R4: The clock enables return only after the synchronized lock has stayed high without a break for the qualifying window. They rise between STABLE_CYCLES and STABLE_CYCLES+4 cycles after the last rise of `lock_in`. Any drop of lock inside the window restarts it.
- R5: If lock stays low for exactly TIMEOUT_CYCLES cycles after `pll_pd_n_o` has been released, a new power-down pulse starts and `retry_flag_o` is set. The flag stays high until reset.
- R6: During reset and right after it, `pll_pd_n_o` is 0, all enables are 0, `recovering_o` is 1, `loss_count_o` is 0 and `retry_flag_o` is 0. The startup pulse and the relock that follows do not count as a loss event.
- R7: `loss_count_o` rises by exactly one for each loss of lock seen while the clocks are enabled. It holds at the all-ones value of its CNT_W bits (default 16).
- R8: `recovering_o` is high exactly while the clock enables are low, from detection of a loss until the enables return.
- R9: All NUM_EN bits of `clk_en_o` always carry the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock, independent of the PLL |
| rst | input | 1 | Synchronous active-high reset |
| lock_in | input | 1 | PLL lock indication, asynchronous |
| pll_pd_n_o | output | 1 | Active-low power-down drive to the PLL |
| clk_en_o | output | NUM_EN | Enables for the glitch-free clock gates, 1 = clock running |
| recovering_o | output | 1 | High while a recovery is in progress |
| retry_flag_o | output | 1 | Sticky flag: a relock timed out and the pulse was repeated |
| loss_count_o | output | CNT_W | Saturating count of loss-of-lock events |

## Verification
A sequencer in the wrong state shows up at once at the ports. An early or late power-down edge changes the measured pulse width, or lets `pll_pd_n_o` go low while an enable is still high. A wrong timer load moves the enable rise outside its window of a few cycles after lock returns. It can also shift the retry pulse away from exactly TIMEOUT_CYCLES. A missed or doubled event shows in the counter at the end of that same recovery.

// File: rtl/plr_pkg.sv
package plr_pkg;
  typedef enum logic [2:0] {
    IDLE_LOCKED = 3'd0,
    GATE        = 3'd1,
    PD_ASSERT   = 3'd2,
    WAIT_LOCK   = 3'd3,
    STABILIZE   = 3'd4,
    UNGATE      = 3'd5
  } plr_state_e;
endpackage

// File: rtl/plr_sync.sv
module plr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk) begin
    if (rst) ff_q <= '0;
    else     ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/plr_timer.sv
module plr_timer #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= W'(RST_VAL);
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/plr_sat_cnt.sv
module plr_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst)                         cnt_o <= '0;
    else if (inc_i && cnt_o != '1)   cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/pll_relock_ctrl.sv
module pll_relock_ctrl
  import plr_pkg::*;
#(
  parameter int PD_CYCLES      = 64,
  parameter int STABLE_CYCLES  = 256,
  parameter int TIMEOUT_CYCLES = 4096,
  parameter int CNT_W          = 16,
  parameter int NUM_EN         = 2,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lock_in,
  output logic              pll_pd_n_o,
  output logic [NUM_EN-1:0] clk_en_o,
  output logic              recovering_o,
  output logic              retry_flag_o,
  output logic [CNT_W-1:0]  loss_count_o
);
  localparam int MAX_A  = (PD_CYCLES > STABLE_CYCLES) ? PD_CYCLES : STABLE_CYCLES;
  localparam int MAX_C  = (MAX_A > TIMEOUT_CYCLES) ? MAX_A : TIMEOUT_CYCLES;
  localparam int TMR_W  = $clog2(MAX_C + 1);
  localparam logic [TMR_W-1:0] PD_LOAD  = TMR_W'(PD_CYCLES - 1);
  localparam logic [TMR_W-1:0] ST_LOAD  = TMR_W'(STABLE_CYCLES - 1);
  localparam logic [TMR_W-1:0] TO_LOAD  = TMR_W'(TIMEOUT_CYCLES - 1);

  plr_state_e       state_q, state_d;
  logic             lock_s;
  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_done;
  logic             loss_evt;
  logic             retry_set;
  logic             en_next;

  plr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (lock_in),
    .q_o (lock_s)
  );

  plr_timer #(.W(TMR_W), .RST_VAL(PD_CYCLES - 1)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  plr_sat_cnt #(.W(CNT_W)) u_loss_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc_i (loss_evt),
    .cnt_o (loss_count_o)
  );

  // Sequencer: gate, power-down pulse, wait, qualify, ungate
  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    loss_evt  = 1'b0;
    retry_set = 1'b0;
    unique case (state_q)
      IDLE_LOCKED: begin
        if (!lock_s) begin
          state_d  = GATE;
          loss_evt = 1'b1;
        end
      end
      GATE: begin
        state_d  = PD_ASSERT;
        tmr_load = 1'b1;
        tmr_val  = PD_LOAD;
      end
      PD_ASSERT: begin
        if (tmr_done) begin
          state_d  = WAIT_LOCK;
          tmr_load = 1'b1;
          tmr_val  = TO_LOAD;
        end
      end
      WAIT_LOCK: begin
        if (lock_s) begin
          state_d  = STABILIZE;
          tmr_load = 1'b1;
          tmr_val  = ST_LOAD;
        end else if (tmr_done) begin
          state_d   = PD_ASSERT;
          tmr_load  = 1'b1;
          tmr_val   = PD_LOAD;
          retry_set = 1'b1;
        end
      end
      STABILIZE: begin
        if (!lock_s) begin
          state_d  = WAIT_LOCK;
          tmr_load = 1'b1;
          tmr_val  = TO_LOAD;
        end else if (tmr_done) begin
          state_d = UNGATE;
        end
      end
      UNGATE: begin
        state_d = IDLE_LOCKED;
      end
      default: begin
        state_d  = PD_ASSERT;
        tmr_load = 1'b1;
        tmr_val  = PD_LOAD;
      end
    endcase
  end

  assign en_next = (state_d == UNGATE) || (state_d == IDLE_LOCKED);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= PD_ASSERT;
      pll_pd_n_o   <= 1'b0;
      recovering_o <= 1'b1;
      retry_flag_o <= 1'b0;
    end else begin
      state_q      <= state_d;
      pll_pd_n_o   <= (state_d != PD_ASSERT);
      recovering_o <= !en_next;
      retry_flag_o <= retry_flag_o | retry_set;
    end
  end

  // One registered enable per gated clock domain
  for (genvar g = 0; g < NUM_EN; g++) begin : g_en
    always_ff @(posedge clk) begin
      if (rst) clk_en_o[g] <= 1'b0;
      else     clk_en_o[g] <= en_next;
    end
  end
endmodule

module plr_checker #(
  parameter int CNT_W  = 16,
  parameter int NUM_EN = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              lock_sync,
  input logic              pll_pd_n_o,
  input logic [NUM_EN-1:0] clk_en_o,
  input logic              recovering_o,
  input logic              retry_flag_o,
  input logic [CNT_W-1:0]  loss_count_o
);
  // R2
  pd_while_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    !pll_pd_n_o |-> (clk_en_o == '0));

  // R2
  pd_after_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pll_pd_n_o) |-> $past(clk_en_o == '0));

  // R4
  ungate_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_en_o[0]) |-> $past(lock_sync));

  // R5
  retry_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $past(retry_flag_o) |-> retry_flag_o);

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (loss_count_o != $past(loss_count_o)) |-> (loss_count_o == CNT_W'($past(loss_count_o) + 1'b1)));

  // R7
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(loss_count_o) == '1) |-> (loss_count_o == '1));

  // R8
  recovering_match_chk: assert property (@(posedge clk) disable iff (rst)
    recovering_o == (clk_en_o == '0));

  // R9
  enables_equal_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en_o == '0) || (clk_en_o == '1));
endmodule

bind pll_relock_ctrl plr_checker #(.CNT_W(CNT_W), .NUM_EN(NUM_EN)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .lock_sync    (lock_s),
  .pll_pd_n_o   (pll_pd_n_o),
  .clk_en_o     (clk_en_o),
  .recovering_o (recovering_o),
  .retry_flag_o (retry_flag_o),
  .loss_count_o (loss_count_o)
);

// File: tb/pll_relock_ctrl_tb_top.sv
module pll_relock_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PD  = 16;
  localparam int ST  = 32;
  localparam int TO  = 120;
  localparam int CW  = 4;
  localparam int NE  = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lock_in = 1'b0;
  logic          pd_n;
  logic [NE-1:0] en;
  logic          rec;
  logic          retry;
  logic [CW-1:0] cnt;

  int checks = 0;
  int errors = 0;
  int exp_events = 0;
  bit mon_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_relock_ctrl #(
    .PD_CYCLES(PD), .STABLE_CYCLES(ST), .TIMEOUT_CYCLES(TO),
    .CNT_W(CW), .NUM_EN(NE), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst(rst), .lock_in(lock_in), .pll_pd_n_o(pd_n),
    .clk_en_o(en), .recovering_o(rec), .retry_flag_o(retry), .loss_count_o(cnt)
  );

  function automatic int sat_exp(int n);
    int mx = (1 << CW) - 1;
    return (n > mx) ? mx : n;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Continuous port relations, sampled away from the active edge
  always @(negedge clk) begin
    if (mon_on && !rst) begin
      chk(!(pd_n == 1'b0 && en != '0), "R2", "power-down low while enabled", int'(en), 0);
      chk(en == '0 || en == '1, "R9", "enable bits differ", int'(en), 0);
      chk(rec == (en == '0), "R8", "recovering vs enables", int'(rec), int'(en == '0));
    end
  end

  // One full loss/recovery episode
  task automatic recover(int dly, bit glitch, bit timeout);
    int t;
    int w;
    @(negedge clk);
    lock_in = 1'b0;
    t = 0;
    do begin @(negedge clk); t++; end while (en[0] && t < 50);
    chk(t <= 4, "R1", "cycles to gate", t, 3);
    chk(pd_n == 1'b1, "R2", "power-down still high at gating", int'(pd_n), 1);
    exp_events++;
    t = 0;
    while (pd_n && t < 50) begin @(negedge clk); t++; end
    chk(t >= 1, "R2", "gap between gating and power-down", t, 1);
    w = 0;
    while (!pd_n && w < 1000) begin @(negedge clk); w++; end
    chk(w == PD, "R3", "power-down width", w, PD);
    if (timeout) begin
      w = 0;
      while (pd_n && w < 1000) begin @(negedge clk); w++; end
      chk(w == TO, "R5", "cycles before retry pulse", w, TO);
      chk(retry == 1'b1, "R5", "retry flag after timeout", int'(retry), 1);
      w = 0;
      while (!pd_n && w < 1000) begin @(negedge clk); w++; end
      chk(w == PD, "R3", "retry power-down width", w, PD);
    end
    repeat (dly) @(negedge clk);
    lock_in = 1'b1;
    if (glitch) begin
      repeat (ST/2) @(negedge clk);
      lock_in = 1'b0;
      repeat (2) @(negedge clk);
      lock_in = 1'b1;
      chk(en == '0, "R4", "enables off after lock glitch", int'(en), 0);
    end
    t = 0;
    while (!en[0] && t < 1000) begin @(negedge clk); t++; end
    chk(t >= ST && t <= ST + 4, "R4", "lock-to-enable delay", t, ST + 3);
    chk(int'(cnt) == sat_exp(exp_events), "R7", "loss count", int'(cnt), sat_exp(exp_events));
    chk(rec == 1'b0, "R8", "recovering after ungate", int'(rec), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    errors++;
    finish_run();
  end

  initial begin
    int t;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    // R6 reset values
    chk(pd_n == 1'b0, "R6", "pd_n in reset", int'(pd_n), 0);
    chk(en == '0, "R6", "enables in reset", int'(en), 0);
    chk(rec == 1'b1, "R6", "recovering in reset", int'(rec), 1);
    chk(cnt == '0, "R6", "count in reset", int'(cnt), 0);
    chk(retry == 1'b0, "R6", "retry in reset", int'(retry), 0);
    rst = 1'b0;
    mon_on = 1'b1;
    @(negedge clk);
    chk(pd_n == 1'b0, "R6", "startup power-down pulse", int'(pd_n), 0);
    t = 0;
    while (!pd_n && t < 1000) begin @(negedge clk); t++; end
    repeat (5) @(negedge clk);
    lock_in = 1'b1;
    t = 0;
    while (!en[0] && t < 1000) begin @(negedge clk); t++; end
    chk(t >= ST && t <= ST + 4, "R4", "startup lock-to-enable delay", t, ST + 3);
    chk(cnt == '0, "R6", "startup not counted", int'(cnt), 0);
    chk(retry == 1'b0, "R6", "no retry at startup", int'(retry), 0);

    // Directed corners
    recover(5, 1'b0, 1'b0);
    recover(3, 1'b1, 1'b0);
    recover(0, 1'b0, 1'b0);
    recover(10, 1'b0, 1'b1);

    // Random episodes, driving the counter into saturation (R7)
    for (int k = 0; k < 14; k++) begin
      repeat ($urandom_range(2, 20)) @(negedge clk);
      recover(int'($urandom_range(0, 40)), bit'($urandom_range(0, 1)), 1'b0);
    end
    chk(cnt == '1, "R7", "count saturated", int'(cnt), (1 << CW) - 1);
    chk(retry == 1'b1, "R5", "retry flag stays set", int'(retry), 1);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule